// File: doc/BRIEF.md
# Carry-Free Sum-Equals-Value Comparator

This combinational block answers one question without building an adder: does the sum of two operands, or of three operands, equal a compare value modulo 2^W? It adds the inverted compare value as one more summand. It keeps the result in carry-save form, as a sum vector and a carry vector shifted up one place. The total is all ones exactly when the sum vector is the bitwise inverse of the carry vector. Each bit position therefore yields a local match term, and no carry ripples across the word. The terms depend only on the operand and compare bits at that position and at the position below it. The final flag is the AND of all terms.

The block sits in front of a decoder, such as a row decoder whose row number is the compare value and whose index is a base plus an offset. It is also useful wherever an equality against a sum must be settled faster than a full add. A parameter adds an optional third operand. When it is enabled, a row of full adders first folds the three operands into two. The per-bit terms come out on a port for debug.

Top module: `sumeq_cmp`

## Requirements
- R1: With the third operand disabled (HAS_C=0), `hit` is 1 exactly when (op_a + op_b) mod 2^W equals cmp_k.
- R2: With the third operand enabled (HAS_C=1), `hit` is 1 exactly when (op_a + op_b + op_c) mod 2^W equals cmp_k.
- R3: With HAS_C=0, the value on op_c has no effect on `hit` or on `bit_hit`.
- R4: For a bit i >= 1, with t = ~cmp_k and the reduced pair (x, y): bit_hit[i] = x[i] ^ y[i] ^ t[i] ^ maj(x[i-1], y[i-1], t[i-1]).
- R5: Bit 0 has no incoming carry, so bit_hit[0] = x[0] ^ y[0] ^ ~cmp_k[0]. It is 1 exactly when x[0] ^ y[0] equals cmp_k[0].
- R6: `hit` is 1 exactly when every bit of `bit_hit` is 1.
- R7: The carry out of bit W-1 is dropped. A sum that wraps past 2^W matches its value modulo 2^W. For example, all ones plus 1 matches 0.
- R8: The reduced pair is x = op_a, y = op_b when HAS_C=0. When HAS_C=1 it is x = op_a ^ op_b ^ op_c, with y[0] = 0 and y[j+1] = maj(op_a[j], op_b[j], op_c[j]); the top carry is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | W | First summand |
| op_b | input | W | Second summand |
| op_c | input | W | Third summand, used only when HAS_C=1 |
| cmp_k | input | W | Value the sum is compared against |
| hit | output | 1 | 1 when the sum equals cmp_k modulo 2^W |
| bit_hit | output | W | Per-bit local match terms |

## Verification
A 5-bit two-operand instance is swept over every combination of summands and compare value, with a random, unused third operand. Getting the bit-0 carry wrong, or feeding op_c in by accident, shows up there as false matches or missed matches. A 5-bit three-operand instance gets the same sweep. A 32-bit instance is driven with exact sums, single-bit near misses and wrapping sums. A mistake in the specialised carry (AND against OR), or a top carry that leaks into the flag, makes exact sums miss or near misses match. Every debug term is compared bit by bit with the local formula, so a term that draws on the wrong neighbour bit is caught even when the flag happens to agree.

// File: rtl/sumeq_pkg.sv
package sumeq_pkg;

  // One full-adder sum bit.
  function automatic logic fa_sum(input logic a, input logic b, input logic c);
    return a ^ b ^ c;
  endfunction

  // One full-adder carry bit (majority of three).
  function automatic logic fa_carry(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/sumeq_csa.sv
// Folds three summands into a sum/carry pair with equal total modulo 2^W.
module sumeq_csa #(
  parameter int W = 32
) (
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [W-1:0] in_c,
  output logic [W-1:0] red_x,
  output logic [W-1:0] red_y
);
  import sumeq_pkg::*;

  assign red_y[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_col
    assign red_x[i] = fa_sum(in_a[i], in_b[i], in_c[i]);
    if (i < W - 1) begin : g_cy
      assign red_y[i+1] = fa_carry(in_a[i], in_b[i], in_c[i]);
    end
  end

  logic [W-1:0] fold_tot;
  logic [W-1:0] orig_tot;
  always_comb begin
    fold_tot = red_x + red_y;
    orig_tot = in_a + in_b + in_c;
    // R8
    csa_fold_chk: assert (fold_tot == orig_tot)
      else $error("carry-save fold changed the total");
  end

endmodule

// File: rtl/sumeq_terms.sv
// Per-bit local match terms: each uses only bits i and i-1.
module sumeq_terms #(
  parameter int W = 32
) (
  input  logic [W-1:0] pair_x,
  input  logic [W-1:0] pair_y,
  input  logic [W-1:0] cmp_val,
  output logic [W-1:0] term
);

  logic [W-1:0] ref_low;
  always_comb ref_low = pair_x + pair_y;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s_loc;
    logic c_in;
    // Third summand bit is ~cmp_val[i]: xor when it is 0, xnor when it is 1.
    assign s_loc = cmp_val[i] ? (pair_x[i] ^ pair_y[i]) : ~(pair_x[i] ^ pair_y[i]);
    if (i == 0) begin : g_lsb
      assign c_in = 1'b0;
    end else begin : g_up
      // Carry from the position below: and when its third bit is 0, or when 1.
      assign c_in = cmp_val[i-1] ? (pair_x[i-1] & pair_y[i-1])
                                 : (pair_x[i-1] | pair_y[i-1]);
    end
    assign term[i] = s_loc ^ c_in;

    always_comb begin
      // R4 R5: all terms up to i set exactly when the low i+1 sum bits match
      prefix_match_chk: assert ((&term[i:0]) == (ref_low[i:0] == cmp_val[i:0]))
        else $error("local term prefix disagrees at bit %0d", i);
    end
  end

endmodule

// File: rtl/sumeq_and_tree.sv
// Two-level AND reduction of the per-bit terms.
module sumeq_and_tree #(
  parameter int N   = 32,
  parameter int GRP = 4
) (
  input  logic [N-1:0] in_bits,
  output logic         all_set
);
  localparam int NG = (N + GRP - 1) / GRP;

  logic [NG-1:0] part;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    localparam int LO = g * GRP;
    localparam int HI = (LO + GRP - 1 < N) ? LO + GRP - 1 : N - 1;
    assign part[g] = &in_bits[HI:LO];
  end

  assign all_set = &part;

  always_comb begin
    // R6
    and_reduce_chk: assert (all_set == ($countones(in_bits) == N))
      else $error("reduction tree output wrong");
  end

endmodule

// File: rtl/sumeq_cmp.sv
module sumeq_cmp #(
  parameter int W     = 32,
  parameter int HAS_C = 1,
  parameter int GRP   = 4
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] op_c,
  input  logic [W-1:0] cmp_k,
  output logic         hit,
  output logic [W-1:0] bit_hit
);

  logic [W-1:0] pair_x;
  logic [W-1:0] pair_y;

  if (HAS_C != 0) begin : g_three
    sumeq_csa #(.W(W)) u_csa (
      .in_a  (op_a),
      .in_b  (op_b),
      .in_c  (op_c),
      .red_x (pair_x),
      .red_y (pair_y)
    );
  end else begin : g_two
    assign pair_x = op_a;
    assign pair_y = op_b;
  end

  sumeq_terms #(.W(W)) u_terms (
    .pair_x  (pair_x),
    .pair_y  (pair_y),
    .cmp_val (cmp_k),
    .term    (bit_hit)
  );

  sumeq_and_tree #(.N(W), .GRP(GRP)) u_tree (
    .in_bits (bit_hit),
    .all_set (hit)
  );

  logic [W-1:0] ref_sum;
  always_comb begin
    ref_sum = op_a + op_b + ((HAS_C != 0) ? op_c : '0);
    // R1 R2 R7
    hit_ref_chk: assert (hit == (ref_sum == cmp_k))
      else $error("match flag disagrees with modular sum");
  end

endmodule

// File: tb/sumeq_cmp_bench.sv
`timescale 1ns/1ps
module sumeq_cmp_bench;

  logic clk;
  logic rst_n;
  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  logic [31:0] a32, b32, c32, k32, bits32;
  logic        hit32;
  logic [4:0]  a5, b5, c5, k5, bits5, bits5c;
  logic        hit5, hit5c;

  sumeq_cmp #(.W(32), .HAS_C(1)) u_sumeq_cmp (
    .op_a(a32), .op_b(b32), .op_c(c32), .cmp_k(k32), .hit(hit32), .bit_hit(bits32));
  sumeq_cmp #(.W(5), .HAS_C(0)) u_sumeq_cmp_w5 (
    .op_a(a5), .op_b(b5), .op_c(c5), .cmp_k(k5), .hit(hit5), .bit_hit(bits5));
  sumeq_cmp #(.W(5), .HAS_C(1)) u_sumeq_cmp_w5c (
    .op_a(a5), .op_b(b5), .op_c(c5), .cmp_k(k5), .hit(hit5c), .bit_hit(bits5c));

  typedef struct {
    int          unit;
    logic        exp_hit;
    logic [31:0] exp_bits;
    string       req;
  } item_t;
  item_t sbq[$];

  function automatic logic mj(input logic p, input logic q, input logic r);
    return (p & q) | (p & r) | (q & r);
  endfunction

  // R4 R5 local terms from the reduced pair
  function automatic logic [31:0] exp_terms(input logic [31:0] x, input logic [31:0] y,
                                            input logic [31:0] k, input int w);
    logic [31:0] t;
    logic [31:0] r;
    t = ~k;
    r = '0;
    for (int i = 0; i < w; i++) begin
      r[i] = x[i] ^ y[i] ^ t[i];
      if (i > 0) r[i] = r[i] ^ mj(x[i-1], y[i-1], t[i-1]);
    end
    return r;
  endfunction

  // R8 three-operand fold
  function automatic logic [31:0] fold_y(input logic [31:0] a, input logic [31:0] b,
                                         input logic [31:0] c, input int w);
    logic [31:0] r;
    r = '0;
    for (int j = 0; j + 1 < w; j++) r[j+1] = mj(a[j], b[j], c[j]);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] got,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic drive(input logic [31:0] ia, input logic [31:0] ib, input logic [31:0] ic,
                       input logic [31:0] ik, input logic [4:0] sa, input logic [4:0] sb,
                       input logic [4:0] sc, input logic [4:0] sk);
    item_t it;
    logic [31:0] s32;
    logic [4:0]  s5, s5c;
    @(posedge clk);
    #1;
    a32 = ia; b32 = ib; c32 = ic; k32 = ik;
    a5 = sa; b5 = sb; c5 = sc; k5 = sk;
    s32 = ia + ib + ic;
    s5  = sa + sb;
    s5c = sa + sb + sc;
    it.unit = 0; it.exp_hit = (s32 == ik); it.req = "R2,R7,R8";
    it.exp_bits = exp_terms(ia ^ ib ^ ic, fold_y(ia, ib, ic, 32), ik, 32);
    sbq.push_back(it);
    it.unit = 1; it.exp_hit = (s5 == sk); it.req = "R1,R3,R4,R5";
    it.exp_bits = exp_terms({27'd0, sa}, {27'd0, sb}, {27'd0, sk}, 5);
    sbq.push_back(it);
    it.unit = 2; it.exp_hit = (s5c == sk); it.req = "R2,R8";
    it.exp_bits = exp_terms({27'd0, sa ^ sb ^ sc},
                            fold_y({27'd0, sa}, {27'd0, sb}, {27'd0, sc}, 5), {27'd0, sk}, 5);
    sbq.push_back(it);
  endtask

  // Monitor: pops expected items and compares away from the driving edge.
  always @(negedge clk) begin
    item_t it;
    logic        g_hit;
    logic [31:0] g_bits;
    int          w;
    while (sbq.size() > 0) begin
      it = sbq.pop_front();
      case (it.unit)
        0:       begin g_hit = hit32; g_bits = bits32;           w = 32; end
        1:       begin g_hit = hit5;  g_bits = {27'd0, bits5};  w = 5;  end
        default: begin g_hit = hit5c; g_bits = {27'd0, bits5c}; w = 5;  end
      endcase
      chk(g_hit == it.exp_hit, {it.req, " hit"}, {31'd0, g_hit}, {31'd0, it.exp_hit});
      chk(g_bits == it.exp_bits, {it.req, " bit_hit"}, g_bits, it.exp_bits);
      // R6
      chk(g_hit == ($countones(g_bits) == w), "R6 flag vs terms", {31'd0, g_hit}, g_bits);
    end
  end

  initial begin
    #900000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] ra, rb, rc, rs;
    rst_n = 1'b0;
    a32 = '0; b32 = '0; c32 = '0; k32 = '0;
    a5 = '0; b5 = '0; c5 = '0; k5 = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Idle state: all zero inputs match (R1 R2)
    drive('0, '0, '0, '0, '0, '0, '0, '0);
    // R7 wrap cases
    drive(32'hffff_ffff, 32'h1, 32'h0, 32'h0, 5'h1f, 5'h01, 5'h00, 5'h00);
    drive(32'h8000_0000, 32'h8000_0000, 32'h0, 32'h0, 5'h10, 5'h10, 5'h00, 5'h00);
    drive(32'hffff_ffff, 32'hffff_ffff, 32'hffff_ffff, 32'hffff_fffd,
          5'h1f, 5'h1f, 5'h1f, 5'h1d);
    drive(32'hffff_ffff, 32'h1, 32'h0, 32'h1, 5'h1f, 5'h01, 5'h00, 5'h01);
    // Exhaustive 5-bit sweep (R1 R2 R3) with mixed 32-bit vectors
    for (int idx = 0; idx < 32768; idx++) begin
      ra = $urandom; rb = $urandom; rc = $urandom;
      rs = ra + rb + rc;
      case (idx % 4)
        0: drive(ra, rb, rc, $urandom, idx[4:0], idx[9:5], 5'($urandom), idx[14:10]);
        1: drive(ra, rb, rc, rs, idx[4:0], idx[9:5], 5'($urandom), idx[14:10]);
        2: drive(ra, rb, rc, rs ^ (32'h1 << (idx % 32)), idx[4:0], idx[9:5],
                 5'($urandom), idx[14:10]);
        default: drive(32'hffff_ffff - (ra & 32'hff), rb | 32'h8000_0000, rc,
                       (32'hffff_ffff - (ra & 32'hff)) + (rb | 32'h8000_0000) + rc,
                       idx[4:0], idx[9:5], 5'($urandom), idx[14:10]);
      endcase
    end
    repeat (3) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule